// File: doc/BRIEF.md
# Auto-Reload 8-Bit PWM Channel

This block is a single compare channel running off a free-running 8-bit timebase. Its output rises when the count reaches the channel's working compare value and falls when the count rolls over from its top value back to zero. The high time per period is therefore the stretch of counts from the compare value up to 255.

Software never updates the working compare value mid-period. A staging byte is written instead. At every rollover the staging byte is copied into the working byte, so a duty change always starts at a period boundary and the output never glitches.

The channel enable follows the order of writes. Writing the working byte switches the channel off, and writing the staging byte switches it back on. A full update therefore writes the working byte first and the staging byte last. Two sticky flags record compare hits and rollovers, and software clears them by writing ones.

The write port is a single-cycle strobe. Every write is accepted in the cycle it is presented, so the port needs no back-pressure and has no ready signal. The counter, compare bytes, enable and flags are brought out as plain status pins.

Top module: `pwm8_chan`

## Requirements
- R1: With the channel enabled and the working byte S stable, `pwm_out` is 1 in the cycle `cnt_out` first equals S, and 0 in the cycle `cnt_out` equals S-1, for S > 0.
- R2: `pwm_out` falls to 0 in the cycle `cnt_out` rolls from 0xFF to 0x00, unless the staging byte is 0x00.
- R3: At every rollover the working byte (`act_cmp`) takes the staging byte's value; between rollovers it keeps its value.
- R4: A write to select 0 (working byte) clears `chan_en`, and a write to select 1 (staging byte) sets it.
- R5: While `chan_en` is 0, `pwm_out` stays 0.
- R6: In steady state with staging value S, `pwm_out` is high for exactly 256-S of every 256 counter ticks.
- R7: When bit 0 of the control register (select 2) is 1, `match_flag` is set on each compare hit; when that bit is 0, compare hits leave `match_flag` alone.
- R8: `ovf_flag` is set at every rollover. Writing select 3 with bit 1 set clears it and with bit 0 set clears `match_flag`; a set in the same cycle beats the clear.
- R9: If a compare hit and a rollover fall on the same tick (staging byte 0x00), the set wins and `pwm_out` stays high without a break.
- R10: `cnt_out` advances by one only on cycles where `tick_en` is 1, and otherwise holds.
- R11: A write to the working byte in the same cycle as a rollover reload stores the written value, not the staging byte, and still clears `chan_en`.
- R12: After reset, the counter, both compare bytes, the control bit, both flags, `chan_en` and `pwm_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 working, 1 staging, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |
| cnt_out | output | 8 | Timebase count |
| act_cmp | output | 8 | Working compare byte |
| shd_cmp | output | 8 | Staging compare byte |
| chan_en | output | 1 | Channel compare enable |
| match_flag | output | 1 | Sticky compare-hit flag |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
The bench targets the extremes of the duty range. With a staging value of 0x00, a design that let the rollover clear win would show a one-tick notch every period. With 0xFF, an off-by-one compare would give either zero or two high ticks instead of one.

It also collides a working-byte write with a rollover. A design that let the reload win would lose the written value, and one that skipped the enable clear would keep driving the output.

Further checks look for three faults: a reload that lands before the period boundary, a match flag that sets while its enable bit is 0, and a counter that moves while `tick_en` is low.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  typedef enum logic [1:0] {
    SEL_ACT  = 2'd0,
    SEL_SHD  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;

  localparam int CTRL_MATEN_BIT = 0;
  localparam int FLAG_MATCH_BIT = 0;
  localparam int FLAG_OVF_BIT   = 1;
endpackage

// File: rtl/pwm8_timebase.sv
module pwm8_timebase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  assign cnt_nxt = cnt_q + 1'b1;
  assign wrap    = tick_en && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         wrap,
  output logic [W-1:0] act_q,
  output logic [W-1:0] shd_q,
  output logic         en_q,
  output logic         mat_en_q,
  output logic         clr_match,
  output logic         clr_ovf
);
  reg_sel_e sel;
  logic     wr_act, wr_shd, wr_ctrl, wr_flag;

  assign sel     = reg_sel_e'(wr_sel);
  assign wr_act  = wr_en && (sel == SEL_ACT);
  assign wr_shd  = wr_en && (sel == SEL_SHD);
  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign wr_flag = wr_en && (sel == SEL_FLAG);

  assign clr_match = wr_flag && wr_data[FLAG_MATCH_BIT];
  assign clr_ovf   = wr_flag && wr_data[FLAG_OVF_BIT];

  // Working byte: a bus write beats the rollover reload
  always_ff @(posedge clk) begin
    if (!rst_n)      act_q <= '0;
    else if (wr_act) act_q <= wr_data;
    else if (wrap)   act_q <= shd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      shd_q <= '0;
    else if (wr_shd) shd_q <= wr_data;
  end

  // Write-order enable: working byte off, staging byte on
  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (wr_act) en_q <= 1'b0;
    else if (wr_shd) en_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mat_en_q <= 1'b0;
    else if (wr_ctrl) mat_en_q <= wr_data[CTRL_MATEN_BIT];
  end
endmodule

// File: rtl/pwm8_outstage.sv
module pwm8_outstage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wrap,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] act_q,
  input  logic [W-1:0] shd_q,
  input  logic         en_q,
  input  logic         mat_en_q,
  input  logic         clr_match,
  input  logic         clr_ovf,
  output logic         pwm_out,
  output logic         match_flag,
  output logic         ovf_flag
);
  localparam int NFLAG = 2;

  logic [W-1:0]     act_eff;
  logic             hit;
  logic             pwm_q;
  logic [NFLAG-1:0] fl_set, fl_clr, fl_q;

  // The value compared is the one in force after this tick's reload
  assign act_eff = wrap ? shd_q : act_q;
  assign hit     = tick_en && en_q && (cnt_nxt == act_eff);

  always_ff @(posedge clk) begin
    if (!rst_n)     pwm_q <= 1'b0;
    else if (!en_q) pwm_q <= 1'b0;
    else if (hit)   pwm_q <= 1'b1;   // set beats rollover clear
    else if (wrap)  pwm_q <= 1'b0;
  end

  assign pwm_out = pwm_q && en_q;

  assign fl_set = {wrap, hit && mat_en_q};
  assign fl_clr = {clr_ovf, clr_match};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         fl_q[g] <= 1'b0;
      else if (fl_set[g]) fl_q[g] <= 1'b1;
      else if (fl_clr[g]) fl_q[g] <= 1'b0;
    end
  end

  assign match_flag = fl_q[0];
  assign ovf_flag   = fl_q[1];
endmodule

// File: rtl/pwm8_chan.sv
module pwm8_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         pwm_out,
  output logic [W-1:0] cnt_out,
  output logic [W-1:0] act_cmp,
  output logic [W-1:0] shd_cmp,
  output logic         chan_en,
  output logic         match_flag,
  output logic         ovf_flag
);
  logic [W-1:0] cnt_nxt;
  logic         wrap;
  logic         mat_en_q, clr_match, clr_ovf;

  pwm8_timebase #(.W(W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cnt_q   (cnt_out),
    .cnt_nxt (cnt_nxt),
    .wrap    (wrap)
  );

  pwm8_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .wrap      (wrap),
    .act_q     (act_cmp),
    .shd_q     (shd_cmp),
    .en_q      (chan_en),
    .mat_en_q  (mat_en_q),
    .clr_match (clr_match),
    .clr_ovf   (clr_ovf)
  );

  pwm8_outstage #(.W(W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .wrap       (wrap),
    .cnt_nxt    (cnt_nxt),
    .act_q      (act_cmp),
    .shd_q      (shd_cmp),
    .en_q       (chan_en),
    .mat_en_q   (mat_en_q),
    .clr_match  (clr_match),
    .clr_ovf    (clr_ovf),
    .pwm_out    (pwm_out),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag)
  );
endmodule

// File: rtl/pwm8_chan_chk.sv
module pwm8_chan_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic         pwm_out,
  input logic [W-1:0] cnt_out,
  input logic [W-1:0] act_cmp,
  input logic [W-1:0] shd_cmp,
  input logic         chan_en,
  input logic         match_flag,
  input logic         ovf_flag
);
  localparam logic [W-1:0] TOP = '1;

  assert_hit_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && chan_en && !wr_en && cnt_out != TOP &&
     W'(cnt_out + 1'b1) == act_cmp) |=> pwm_out);

  assert_wrap_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_out == TOP && shd_cmp != '0 && !wr_en) |=> !pwm_out);

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_out == TOP && !(wr_en && wr_sel == 2'd0))
      |=> act_cmp == $past(shd_cmp));

  assert_act_wr_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> !chan_en);

  assert_shd_wr_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> chan_en);

  assert_off_is_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !pwm_out);

  assert_ovf_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_out == TOP) |=> ovf_flag);

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_out));
endmodule

bind pwm8_chan pwm8_chan_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .pwm_out    (pwm_out),
  .cnt_out    (cnt_out),
  .act_cmp    (act_cmp),
  .shd_cmp    (shd_cmp),
  .chan_en    (chan_en),
  .match_flag (match_flag),
  .ovf_flag   (ovf_flag)
);

// File: tb/test_pwm8_chan.sv
`timescale 1ns/1ps
module test_pwm8_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_out, chan_en, match_flag, ovf_flag;
  logic [7:0] cnt_out, act_cmp, shd_cmp;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // {staging value, expected high ticks per 256}
  localparam logic [16:0] VEC [0:5] = '{
    {8'h00, 9'd256}, {8'h01, 9'd255}, {8'h80, 9'd128},
    {8'hFF, 9'd1},   {8'h40, 9'd192}, {8'hC0, 9'd64}
  };

  always #2.5 clk = ~clk;

  pwm8_chan i_pwm8_chan (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out),
    .cnt_out(cnt_out), .act_cmp(act_cmp), .shd_cmp(shd_cmp),
    .chan_en(chan_en), .match_flag(match_flag), .ovf_flag(ovf_flag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    do @(negedge clk); while (cnt_out !== v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int hi;
    logic [7:0] held;
    idle(3);
    // R12 reset state
    check("R12 pwm", pwm_out, 0);
    check("R12 cnt", cnt_out, 0);
    check("R12 act", act_cmp, 0);
    check("R12 shd", shd_cmp, 0);
    check("R12 en", chan_en, 0);
    check("R12 flags", {match_flag, ovf_flag}, 0);
    rst_n = 1'b1;
    tick_en = 1'b1;

    // R6 / R9: duty table
    for (int v = 0; v < 6; v++) begin
      wr(2'd0, 8'h00);
      wr(2'd1, VEC[v][16:9]);
      idle(520);
      hi = 0;
      for (int k = 0; k < 256; k++) begin
        @(negedge clk);
        if (pwm_out) hi++;
      end
      check((VEC[v][16:9] == 8'h00) ? "R9 always high" : "R6 duty", hi, int'(VEC[v][8:0]));
    end

    // R1 / R2 edge timing with S = 0x40
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);
    idle(300);
    wait_cnt(8'h3F);
    check("R1 before hit", pwm_out, 0);
    @(negedge clk);
    check("R1 at hit", pwm_out, 1);
    wait_cnt(8'hFF);
    check("R2 before wrap", pwm_out, 1);
    @(negedge clk);
    check("R2 after wrap", pwm_out, 0);

    // R3 reload at period boundary only
    wait_cnt(8'h20);
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h33);
    wait_cnt(8'hFF);
    check("R3 held before wrap", act_cmp, 8'h10);
    @(negedge clk);
    check("R3 reloaded", act_cmp, 8'h33);

    // R4 / R5 write-order enable
    wr(2'd0, 8'h10);
    check("R4 act write disables", chan_en, 0);
    hi = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    check("R5 disabled output", hi, 0);
    wr(2'd1, 8'h40);
    check("R4 shd write enables", chan_en, 1);

    // R7 match flag gating
    wait_cnt(8'h80);
    wr(2'd3, 8'h03);
    idle(300);
    check("R7 no flag when off", match_flag, 0);
    wr(2'd2, 8'h01);
    idle(300);
    check("R7 flag when on", match_flag, 1);
    wait_cnt(8'h80);
    wr(2'd3, 8'h01);
    check("R7 w1c match", match_flag, 0);

    // R8 overflow flag
    wait_cnt(8'h80);
    wr(2'd3, 8'h02);
    check("R8 w1c ovf", ovf_flag, 0);
    wait_cnt(8'h00);
    check("R8 set at wrap", ovf_flag, 1);

    // R10 tick gating
    @(negedge clk);
    tick_en = 1'b0;
    held = cnt_out;
    idle(40);
    check("R10 hold", cnt_out, held);
    tick_en = 1'b1;
    @(negedge clk);
    check("R10 advance", cnt_out, 8'(held + 1));

    // R11 write collides with reload
    wr(2'd1, 8'h77);
    wait_cnt(8'hFF);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 bus wins", act_cmp, 8'h5A);
    check("R11 enable cleared", chan_en, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule